// File: doc/BRIEF.md
# Floating-Point Control/Status and Rounding Resolver

This block keeps the control and status state that a floating-point pipeline shares with software. It holds five accrued exception flags (inexact, underflow, overflow, divide-by-zero, invalid) and a three-bit stored rounding mode. Software can read or write the flags alone, the rounding mode alone, or one combined eight-bit view holding both. Arithmetic units report the exceptions they raise with a completion strobe, and those bits are merged into the accrued flags.

For each floating-point instruction the block also resolves the instruction's three-bit rounding field into an effective rounding mode. Field value 7 defers to the stored mode. If the resulting mode is not one of the five defined encodings, the block raises an illegal-instruction indication. Both results are combinational, so the decode stage sees them in the same cycle.

Top module: `fpu_ctrl_status`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the accrued flags and the stored rounding mode to zero.
- R2: The flag bit layout is inexact = bit0, underflow = bit1, overflow = bit2, divide-by-zero = bit3 and invalid = bit4. A write with sw_sel = 0 replaces all five flags with sw_wdata[4:0] in one edge and leaves the rounding mode unchanged.
- R3: A write with sw_sel = 1 loads the stored rounding mode from sw_wdata[2:0]. Any 3-bit value, including 5 to 7, is accepted, and the flags are left unchanged.
- R4: A write with sw_sel = 2 loads the flags from sw_wdata[4:0] and the rounding mode from sw_wdata[7:5] on the same edge.
- R5: sw_rdata is combinational. It is {3'b0, flags} for sw_sel = 0, {5'b0, mode} for sw_sel = 1, {mode, flags} for sw_sel = 2, and zero for sw_sel = 3. A write with sw_sel = 3 changes no state.
- R6: When exc_valid is high, exc_flags is ORed into the accrued flags at the clock edge. Without a software write, hardware never clears a flag bit.
- R7: When a software write to the flags (sw_sel 0 or 2) and exc_valid occur in the same cycle, the flags take the written value. A rounding-only write does not block the exception merge.
- R8: An instruction rounding field of 0 to 4 passes straight to eff_rm (0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity, 4 nearest ties-away), with rm_illegal low.
- R9: An instruction rounding field of 7 makes eff_rm equal the stored rounding mode in the same cycle.
- R10: rm_illegal is high whenever the effective mode is 5, 6 or 7. This covers a field of 5 or 6 given directly, and a field of 7 that resolves to a stored mode of 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_sel | input | 2 | View select: 0 flags, 1 rounding mode, 2 combined, 3 none |
| sw_wdata | input | 8 | Software write data |
| sw_rdata | output | 8 | Software read data for the selected view |
| exc_valid | input | 1 | Arithmetic completion strobe |
| exc_flags | input | 5 | Exceptions raised by the completing operation |
| insn_rm | input | 3 | Rounding field of the current instruction |
| eff_rm | output | 3 | Resolved effective rounding mode |
| rm_illegal | output | 1 | Resolved mode is reserved |

## Verification
Directed patterns come first.

- **Writes through every view.** These show whether each select touches only its own field.
- **Exception strobes with no write.** Several disjoint flag masks in turn show sticky OR accumulation apart from plain replacement.
- **Strobes colliding with writes.** A strobe together with a flag write, and a strobe together with a rounding-only write, separate the two priority cases.
- **Resolver sweeps.** All eight instruction field values are swept with the stored mode at a legal value and then at 5 and 7. This tells direct pass-through apart from dynamic substitution and from reserved-mode detection after substitution.

A long stretch of random mixed traffic follows, compared every cycle against a behavioural model.

// File: rtl/fpu_cs_pkg.sv
package fpu_cs_pkg;
    localparam int CS_FLAG_W   = 5;
    localparam int CS_RM_W     = 3;
    localparam int CS_DYN_CODE = 7;
    localparam int CS_LAST_OK  = 4;

    typedef enum logic [1:0] {
        CS_SEL_FLAGS = 2'd0,
        CS_SEL_ROUND = 2'd1,
        CS_SEL_BOTH  = 2'd2,
        CS_SEL_NONE  = 2'd3
    } cs_sel_e;
endpackage

// File: rtl/fpu_cs_state.sv
module fpu_cs_state
    import fpu_cs_pkg::*;
#(
    parameter int FLAG_W = CS_FLAG_W,
    parameter int RM_W   = CS_RM_W,
    localparam int VIEW_W = FLAG_W + RM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  cs_sel_e           sel,
    input  logic [VIEW_W-1:0] wdata,
    input  logic              exc_valid,
    input  logic [FLAG_W-1:0] exc_flags,
    output logic [FLAG_W-1:0] flags_q,
    output logic [RM_W-1:0]   rm_q
);
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [RM_W-1:0]   rm;
    } state_t;

    state_t st_d, st_q;
    logic   wr_flags_d, wr_rm_d;

    always_comb begin
        st_d       = st_q;
        wr_flags_d = wr_en && (sel == CS_SEL_FLAGS || sel == CS_SEL_BOTH);
        wr_rm_d    = wr_en && (sel == CS_SEL_ROUND || sel == CS_SEL_BOTH);
        // exceptions accumulate; a software flag write then overrides
        if (exc_valid) st_d.flags = st_q.flags | exc_flags;
        if (wr_flags_d) st_d.flags = wdata[FLAG_W-1:0];
        if (wr_rm_d) begin
            if (sel == CS_SEL_BOTH) st_d.rm = wdata[VIEW_W-1:FLAG_W];
            else                    st_d.rm = wdata[RM_W-1:0];
        end
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign flags_q = st_q.flags;
    assign rm_q    = st_q.rm;
endmodule

// File: rtl/fpu_cs_view.sv
module fpu_cs_view
    import fpu_cs_pkg::*;
#(
    parameter int FLAG_W = CS_FLAG_W,
    parameter int RM_W   = CS_RM_W,
    localparam int VIEW_W = FLAG_W + RM_W
) (
    input  cs_sel_e           sel,
    input  logic [FLAG_W-1:0] flags,
    input  logic [RM_W-1:0]   rm,
    output logic [VIEW_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (sel)
            CS_SEL_FLAGS: rdata[FLAG_W-1:0] = flags;
            CS_SEL_ROUND: rdata[RM_W-1:0]   = rm;
            CS_SEL_BOTH:  rdata             = {rm, flags};
            default:      rdata             = '0;
        endcase
    end
endmodule

// File: rtl/fpu_rm_resolve.sv
module fpu_rm_resolve
    import fpu_cs_pkg::*;
#(
    parameter int RM_W     = CS_RM_W,
    parameter int DYN_CODE = CS_DYN_CODE,
    parameter int LAST_OK  = CS_LAST_OK
) (
    input  logic [RM_W-1:0] insn_rm,
    input  logic [RM_W-1:0] stored_rm,
    output logic [RM_W-1:0] eff_rm,
    output logic            illegal
);
    localparam logic [RM_W-1:0] DYN_V  = RM_W'(DYN_CODE);
    localparam logic [RM_W-1:0] LAST_V = RM_W'(LAST_OK);

    always_comb begin
        eff_rm  = (insn_rm == DYN_V) ? stored_rm : insn_rm;
        // reserved check runs after the dynamic substitution
        illegal = (eff_rm > LAST_V);
    end
endmodule

// File: rtl/fpu_ctrl_status.sv
module fpu_ctrl_status
    import fpu_cs_pkg::*;
#(
    parameter int FLAG_W   = CS_FLAG_W,
    parameter int RM_W     = CS_RM_W,
    parameter int DYN_CODE = CS_DYN_CODE,
    parameter int LAST_OK  = CS_LAST_OK,
    localparam int VIEW_W  = FLAG_W + RM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr_en,
    input  logic [1:0]        sw_sel,
    input  logic [VIEW_W-1:0] sw_wdata,
    output logic [VIEW_W-1:0] sw_rdata,
    input  logic              exc_valid,
    input  logic [FLAG_W-1:0] exc_flags,
    input  logic [RM_W-1:0]   insn_rm,
    output logic [RM_W-1:0]   eff_rm,
    output logic              rm_illegal
);
    cs_sel_e           sel;
    logic [FLAG_W-1:0] flags_q;
    logic [RM_W-1:0]   rm_q;

    assign sel = cs_sel_e'(sw_sel);

    fpu_cs_state #(.FLAG_W(FLAG_W), .RM_W(RM_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sw_wr_en),
        .sel       (sel),
        .wdata     (sw_wdata),
        .exc_valid (exc_valid),
        .exc_flags (exc_flags),
        .flags_q   (flags_q),
        .rm_q      (rm_q)
    );

    fpu_cs_view #(.FLAG_W(FLAG_W), .RM_W(RM_W)) u_view (
        .sel   (sel),
        .flags (flags_q),
        .rm    (rm_q),
        .rdata (sw_rdata)
    );

    fpu_rm_resolve #(.RM_W(RM_W), .DYN_CODE(DYN_CODE), .LAST_OK(LAST_OK)) u_resolve (
        .insn_rm   (insn_rm),
        .stored_rm (rm_q),
        .eff_rm    (eff_rm),
        .illegal   (rm_illegal)
    );
endmodule

// File: rtl/fpu_cs_chk.sv
module fpu_cs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sw_wr_en,
    input logic [1:0] sw_sel,
    input logic [7:0] sw_wdata,
    input logic       exc_valid,
    input logic [4:0] exc_flags,
    input logic [2:0] insn_rm,
    input logic [2:0] eff_rm,
    input logic       rm_illegal,
    input logic [4:0] flags_q,
    input logic [2:0] rm_q
);
    logic wr_fl, wr_rm;
    assign wr_fl = sw_wr_en && (sw_sel == 2'd0 || sw_sel == 2'd2);
    assign wr_rm = sw_wr_en && (sw_sel == 2'd1 || sw_sel == 2'd2);

    // R6
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fl |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R6
    exc_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !wr_fl) |=> (flags_q == ($past(flags_q) | $past(exc_flags))));

    // R7
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fl |=> (flags_q == $past(sw_wdata[4:0])));

    // R3
    rm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rm && sw_sel == 2'd1) |=> (rm_q == $past(sw_wdata[2:0])));

    // R4
    both_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rm && sw_sel == 2'd2) |=> (rm_q == $past(sw_wdata[7:5])));

    // R8
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_rm <= 3'd4) |-> (eff_rm == insn_rm && !rm_illegal));

    // R9
    dynamic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_rm == 3'd7) |-> (eff_rm == rm_q));

    // R10
    reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_rm == 3'd5 || insn_rm == 3'd6 || (insn_rm == 3'd7 && rm_q > 3'd4)) |-> rm_illegal);
endmodule

bind fpu_ctrl_status fpu_cs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr_en   (sw_wr_en),
    .sw_sel     (sw_sel),
    .sw_wdata   (sw_wdata),
    .exc_valid  (exc_valid),
    .exc_flags  (exc_flags),
    .insn_rm    (insn_rm),
    .eff_rm     (eff_rm),
    .rm_illegal (rm_illegal),
    .flags_q    (flags_q),
    .rm_q       (rm_q)
);

// File: tb/fpu_ctrl_status_tb.sv
`timescale 1ns/1ps
module fpu_ctrl_status_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sw_wr_en;
    logic [1:0] sw_sel;
    logic [7:0] sw_wdata;
    logic [7:0] sw_rdata;
    logic       exc_valid;
    logic [4:0] exc_flags;
    logic [2:0] insn_rm;
    logic [2:0] eff_rm;
    logic       rm_illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int m_flags = 0;
    int m_rm    = 0;

    always #4 clk = ~clk;

    fpu_ctrl_status u_dut (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .sw_rdata(sw_rdata), .exc_valid(exc_valid),
        .exc_flags(exc_flags), .insn_rm(insn_rm), .eff_rm(eff_rm),
        .rm_illegal(rm_illegal)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cycle(input bit wr, input int sel, input int wd,
                         input bit ev, input int ef, input int irm, input string tag);
        int exp_rd, exp_eff;
        sw_wr_en = wr; sw_sel = 2'(sel); sw_wdata = 8'(wd);
        exc_valid = ev; exc_flags = 5'(ef); insn_rm = 3'(irm);
        #1;
        case (sel)
            0: exp_rd = m_flags;
            1: exp_rd = m_rm;
            2: exp_rd = m_rm * 32 + m_flags;
            default: exp_rd = 0;
        endcase
        exp_eff = (irm == 7) ? m_rm : irm;
        check({tag, " rdata"}, int'(sw_rdata), exp_rd);
        check({tag, " eff_rm"}, int'(eff_rm), exp_eff);
        check({tag, " illegal"}, int'(rm_illegal), (exp_eff > 4) ? 1 : 0);
        @(posedge clk);
        if (ev) m_flags = m_flags | (ef & 31);
        if (wr && (sel == 0 || sel == 2)) m_flags = wd & 31;
        if (wr && sel == 1) m_rm = wd & 7;
        if (wr && sel == 2) m_rm = (wd >> 5) & 7;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sw_wr_en = 0; sw_sel = 0; sw_wdata = 0;
        exc_valid = 0; exc_flags = 0; insn_rm = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // dirty state, then reset again to check R1
        rst_n = 1'b1;
        cycle(1, 2, 8'hFF, 0, 0, 0, "R4 preset");
        rst_n = 1'b0;
        @(posedge clk); m_flags = 0; m_rm = 0; @(negedge clk);
        rst_n = 1'b1;
        cycle(0, 2, 0, 0, 0, 7, "R1 reset state");

        cycle(1, 0, 8'hF5, 0, 0, 0, "R2 flag write");
        cycle(0, 2, 0, 0, 0, 0, "R2 rounding kept");
        cycle(1, 1, 8'hFB, 0, 0, 7, "R3 rounding write 3");
        cycle(0, 2, 0, 0, 0, 7, "R3 flags kept");
        cycle(1, 2, 8'h4A, 0, 0, 1, "R4 combined write");
        cycle(0, 2, 0, 0, 0, 7, "R4 readback");
        cycle(0, 0, 0, 0, 0, 2, "R5 flag view");
        cycle(0, 1, 0, 0, 0, 3, "R5 rounding view");
        cycle(1, 3, 8'hFF, 0, 0, 4, "R5 none select");
        cycle(0, 2, 0, 0, 0, 0, "R5 none ignored");

        cycle(1, 0, 0, 0, 0, 0, "R6 clear");
        cycle(0, 0, 0, 1, 5'h01, 0, "R6 nx");
        cycle(0, 0, 0, 1, 5'h10, 0, "R6 nv");
        cycle(0, 0, 0, 1, 5'h06, 0, "R6 uf of");
        cycle(0, 0, 0, 0, 5'h08, 0, "R6 no strobe");
        cycle(0, 0, 0, 1, 5'h00, 0, "R6 empty strobe");
        cycle(0, 0, 0, 0, 0, 0, "R6 sticky");

        cycle(1, 0, 8'h02, 1, 5'h1C, 0, "R7 write beats exc");
        cycle(1, 1, 8'h01, 1, 5'h08, 0, "R7 rm write merges");
        cycle(1, 2, 8'h00, 1, 5'h1F, 0, "R7 combined beats exc");
        cycle(0, 2, 0, 0, 0, 0, "R7 readback");

        cycle(1, 1, 2, 0, 0, 0, "R8 setup");
        for (int r = 0; r < 8; r++) cycle(0, 1, 0, 0, 0, r, "R8 R9 sweep legal store");
        cycle(1, 1, 5, 0, 0, 0, "R10 store 5");
        for (int r = 0; r < 8; r++) cycle(0, 1, 0, 0, 0, r, "R10 sweep store 5");
        cycle(1, 1, 7, 0, 0, 7, "R10 store 7");
        cycle(0, 1, 0, 0, 0, 7, "R10 dynamic 7");
        cycle(1, 1, 4, 0, 0, 7, "R9 store 4");
        cycle(0, 1, 0, 0, 0, 7, "R9 dynamic ties away");

        for (int k = 0; k < 3000; k++)
            cycle(($urandom % 4) == 0, $urandom % 4, $urandom % 256,
                  ($urandom % 3) == 0, $urandom % 32, $urandom % 8, "R6 R7 R10 random");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule